// File: doc/BRIEF.md
# Integer Add/Subtract Execution Unit

This block is the adder path of a 32-bit RISC integer pipeline. It receives an instruction that has already been decoded into a primary opcode and an extended opcode, along with its control bits and operands. In the same cycle it returns the arithmetic result and the updated status values. Each output comes with its own write-enable, so the writeback stage commits only the state that the instruction actually changes.

The block handles these instruction forms:
- **Register–register:** add, add with carry-out, subtract-from, subtract-from with carry-out, subtract-from extended (with carry-in), and negate.
- **Immediate:** add immediate, add immediate shifted, add immediate with carry-out, the recording variant of add immediate with carry-out, and subtract-from immediate with carry-out.

Subtraction is reversed: the unit computes the second operand minus the first. It does this by feeding the inverted first operand into a single 33-bit adder, with a carry-in of one or of the incoming carry bit. The plain add-immediate forms use a literal zero as the base when the source register field is zero.

Top module: `addSubUnit`

## Requirements
- R1: With primary opcode 31 and extended opcode 266 (add) or 10 (add with carry-out), `result` is `opA + opB` modulo 2^32 and `resultWe` is 1.
- R2: With primary opcode 31, extended opcode 40 or 8 gives `result = ~opA + opB + 1`, and extended opcode 136 gives `result = ~opA + opB + carryIn`.
- R3: With primary opcode 31 and extended opcode 104, `result = ~opA + 1`, and `opB` is ignored.
- R4: Primary opcode 14 adds the sign-extended 16-bit `imm` to a base. Primary opcode 15 adds the sign-extended `imm` shifted left by 16 to a base. For both, the base is zero when `raIsZero` is 1 and `opA` otherwise.
- R5: `carryOut` is bit 32 of the unsigned sum of the two adder inputs and the carry-in term. `carryWe` is 1 only for these forms: extended opcodes 10, 8 and 136, and primary opcodes 12, 13 and 8.
- R6: `ovWe` equals `oeBit` for the register–register forms and is 0 for all other forms. `ovOut` is 1 when both adder inputs have the same sign and the sum's sign differs from it. `soOut` is `sumOvIn`, OR-ed with `ovOut` when `ovWe` is 1.
- R7: `cr0` is {LT, GT, EQ, SO} from bit 3 down to bit 0. LT, GT and EQ come from comparing the signed result with zero, and SO equals `soOut`. `cr0We` equals `rcBit` for the register–register forms, is 1 for primary opcode 13, and is 0 for the other immediate forms.
- R8: Any opcode pair not listed above sets all four write-enables to 0, and `soOut` equals `sumOvIn`.
- R9: Primary opcode 12 computes `opA + simm`. Primary opcode 8 computes `~opA + simm + 1`. For both, `carryWe` is 1 and `cr0We` is 0 regardless of `rcBit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| primOp | input | 6 | Decoded primary opcode |
| extOp | input | 10 | Extended opcode, used when primOp is 31 |
| oeBit | input | 1 | Overflow-enable bit of the instruction |
| rcBit | input | 1 | Record bit of the instruction |
| raIsZero | input | 1 | Source register field is zero |
| opA | input | 32 | First register operand |
| opB | input | 32 | Second register operand |
| imm | input | 16 | Immediate field, sign-extended inside the block |
| carryIn | input | 1 | Current carry bit |
| sumOvIn | input | 1 | Current summary-overflow bit |
| result | output | 32 | Adder result |
| resultWe | output | 1 | Result write-enable |
| carryOut | output | 1 | New carry bit |
| carryWe | output | 1 | Carry write-enable |
| ovOut | output | 1 | Signed overflow of this operation |
| ovWe | output | 1 | Overflow write-enable |
| soOut | output | 1 | Summary-overflow after the update |
| cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr0We | output | 1 | Condition field write-enable |

## Verification
The vector table covers every supported opcode with operand pairs chosen to fall on each side of the unsigned carry boundary. This separates an adder that takes its carry from bit 32 from one that drops or inverts it. Signed-overflow cases include the largest positive value plus one, negation of the most negative value, and a reversed subtract crossing the sign boundary. Together they show whether overflow comes from the adder inputs or from the raw operands. The immediate forms are run with and without the zero-base flag, and with `rcBit` and `oeBit` raised where they must be ignored. Unlisted opcodes confirm that no write-enable leaks through.

// File: rtl/addSubPkg.sv
package addSubPkg;

  typedef enum logic [1:0] {
    A_REG  = 2'd0,
    A_INV  = 2'd1,
    A_ZERO = 2'd2
  } aSelT;

  typedef enum logic [1:0] {
    B_REG   = 2'd0,
    B_IMM   = 2'd1,
    B_IMMHI = 2'd2,
    B_ZERO  = 2'd3
  } bSelT;

  typedef enum logic [1:0] {
    CIN_ZERO  = 2'd0,
    CIN_ONE   = 2'd1,
    CIN_CARRY = 2'd2
  } cinSelT;

  typedef struct packed {
    aSelT   aSel;
    bSelT   bSel;
    cinSelT cinSel;
  } steerT;

  typedef struct packed {
    logic resultWe;
    logic carryWe;
    logic ovWe;
    logic cr0We;
  } enableT;

  localparam int PRIM_W = 6;
  localparam int EXT_W  = 10;

  localparam logic [PRIM_W-1:0] P_XFORM  = 6'd31;
  localparam logic [PRIM_W-1:0] P_ADDI   = 6'd14;
  localparam logic [PRIM_W-1:0] P_ADDIS  = 6'd15;
  localparam logic [PRIM_W-1:0] P_ADDIC  = 6'd12;
  localparam logic [PRIM_W-1:0] P_ADDICR = 6'd13;
  localparam logic [PRIM_W-1:0] P_SUBFIC = 6'd8;

  localparam logic [EXT_W-1:0] X_ADD   = 10'd266;
  localparam logic [EXT_W-1:0] X_ADDC  = 10'd10;
  localparam logic [EXT_W-1:0] X_SUBF  = 10'd40;
  localparam logic [EXT_W-1:0] X_SUBFC = 10'd8;
  localparam logic [EXT_W-1:0] X_SUBFE = 10'd136;
  localparam logic [EXT_W-1:0] X_NEG   = 10'd104;

endpackage

// File: rtl/addSubCtrl.sv
module addSubCtrl
  import addSubPkg::*;
(
  input  logic [PRIM_W-1:0] primOp,
  input  logic [EXT_W-1:0]  extOp,
  input  logic              oeBit,
  input  logic              rcBit,
  input  logic              raIsZero,
  output steerT             steer,
  output enableT            enables
);

  // register-register forms share OE/Rc handling
  function automatic enableT regRegEn(input logic carrying, input logic oe, input logic rc);
    enableT e;
    e.resultWe = 1'b1;
    e.carryWe  = carrying;
    e.ovWe     = oe;
    e.cr0We    = rc;
    return e;
  endfunction

  function automatic enableT immEn(input logic carrying, input logic rec);
    enableT e;
    e.resultWe = 1'b1;
    e.carryWe  = carrying;
    e.ovWe     = 1'b0;
    e.cr0We    = rec;
    return e;
  endfunction

  always_comb begin
    steer   = '{aSel: A_REG, bSel: B_ZERO, cinSel: CIN_ZERO};
    enables = '0;
    case (primOp)
      P_XFORM: begin
        case (extOp)
          X_ADD: begin
            steer   = '{aSel: A_REG, bSel: B_REG, cinSel: CIN_ZERO};
            enables = regRegEn(1'b0, oeBit, rcBit);
          end
          X_ADDC: begin
            steer   = '{aSel: A_REG, bSel: B_REG, cinSel: CIN_ZERO};
            enables = regRegEn(1'b1, oeBit, rcBit);
          end
          X_SUBF: begin
            steer   = '{aSel: A_INV, bSel: B_REG, cinSel: CIN_ONE};
            enables = regRegEn(1'b0, oeBit, rcBit);
          end
          X_SUBFC: begin
            steer   = '{aSel: A_INV, bSel: B_REG, cinSel: CIN_ONE};
            enables = regRegEn(1'b1, oeBit, rcBit);
          end
          X_SUBFE: begin
            steer   = '{aSel: A_INV, bSel: B_REG, cinSel: CIN_CARRY};
            enables = regRegEn(1'b1, oeBit, rcBit);
          end
          X_NEG: begin
            steer   = '{aSel: A_INV, bSel: B_ZERO, cinSel: CIN_ONE};
            enables = regRegEn(1'b0, oeBit, rcBit);
          end
          default: begin
            steer   = '{aSel: A_REG, bSel: B_ZERO, cinSel: CIN_ZERO};
            enables = '0;
          end
        endcase
      end
      P_ADDI: begin
        steer   = '{aSel: (raIsZero ? A_ZERO : A_REG), bSel: B_IMM, cinSel: CIN_ZERO};
        enables = immEn(1'b0, 1'b0);
      end
      P_ADDIS: begin
        steer   = '{aSel: (raIsZero ? A_ZERO : A_REG), bSel: B_IMMHI, cinSel: CIN_ZERO};
        enables = immEn(1'b0, 1'b0);
      end
      P_ADDIC: begin
        steer   = '{aSel: A_REG, bSel: B_IMM, cinSel: CIN_ZERO};
        enables = immEn(1'b1, 1'b0);
      end
      P_ADDICR: begin
        steer   = '{aSel: A_REG, bSel: B_IMM, cinSel: CIN_ZERO};
        enables = immEn(1'b1, 1'b1);
      end
      P_SUBFIC: begin
        steer   = '{aSel: A_INV, bSel: B_IMM, cinSel: CIN_ONE};
        enables = immEn(1'b1, 1'b0);
      end
      default: begin
        steer   = '{aSel: A_REG, bSel: B_ZERO, cinSel: CIN_ZERO};
        enables = '0;
      end
    endcase
  end

endmodule

// File: rtl/addSubPath.sv
module addSubPath
  import addSubPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  steerT             steer,
  input  logic              ovWr,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic              carryIn,
  input  logic              sumOvIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              ovOut,
  output logic              soOut,
  output logic [3:0]        cr0
);

  localparam int SUM_W = DATA_W + 1;
  localparam int EXT_N = DATA_W - IMM_W;

  logic [DATA_W-1:0] immSext;
  logic [DATA_W-1:0] immHigh;
  logic [DATA_W-1:0] addA;
  logic [DATA_W-1:0] addB;
  logic              cinBit;
  logic [SUM_W-1:0]  sumWide;

  generate
    if (EXT_N > 0) begin : g_ext
      assign immSext = {{EXT_N{imm[IMM_W-1]}}, imm};
    end else begin : g_noext
      assign immSext = imm[DATA_W-1:0];
    end
  endgenerate

  assign immHigh = immSext << IMM_W;

  always_comb begin
    case (steer.aSel)
      A_INV:   addA = ~opA;
      A_ZERO:  addA = '0;
      default: addA = opA;
    endcase
    case (steer.bSel)
      B_REG:   addB = opB;
      B_IMM:   addB = immSext;
      B_IMMHI: addB = immHigh;
      default: addB = '0;
    endcase
    case (steer.cinSel)
      CIN_ONE:   cinBit = 1'b1;
      CIN_CARRY: cinBit = carryIn;
      default:   cinBit = 1'b0;
    endcase
  end

  assign sumWide  = {1'b0, addA} + {1'b0, addB} + {{DATA_W{1'b0}}, cinBit};
  assign result   = sumWide[DATA_W-1:0];
  assign carryOut = sumWide[DATA_W];

  assign ovOut = (addA[DATA_W-1] == addB[DATA_W-1]) &&
                 (result[DATA_W-1] != addA[DATA_W-1]);
  assign soOut = sumOvIn | (ovWr & ovOut);

  logic isNeg;
  logic isZero;
  assign isNeg  = result[DATA_W-1];
  assign isZero = (result == '0);
  assign cr0    = {isNeg, !isNeg && !isZero, isZero, soOut};

endmodule

// File: rtl/addSubUnit.sv
module addSubUnit
  import addSubPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [5:0]        primOp,
  input  logic [9:0]        extOp,
  input  logic              oeBit,
  input  logic              rcBit,
  input  logic              raIsZero,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic              carryIn,
  input  logic              sumOvIn,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic              carryOut,
  output logic              carryWe,
  output logic              ovOut,
  output logic              ovWe,
  output logic              soOut,
  output logic [3:0]        cr0,
  output logic              cr0We
);

  steerT  steer;
  enableT enables;

  addSubCtrl u_ctrl (
    .primOp   (primOp),
    .extOp    (extOp),
    .oeBit    (oeBit),
    .rcBit    (rcBit),
    .raIsZero (raIsZero),
    .steer    (steer),
    .enables  (enables)
  );

  addSubPath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_path (
    .steer    (steer),
    .ovWr     (enables.ovWe),
    .opA      (opA),
    .opB      (opB),
    .imm      (imm),
    .carryIn  (carryIn),
    .sumOvIn  (sumOvIn),
    .result   (result),
    .carryOut (carryOut),
    .ovOut    (ovOut),
    .soOut    (soOut),
    .cr0      (cr0)
  );

  assign resultWe = enables.resultWe;
  assign carryWe  = enables.carryWe;
  assign ovWe     = enables.ovWe;
  assign cr0We    = enables.cr0We;

endmodule

// File: rtl/addSubUnit_chk.sv
module addSubUnit_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [5:0]        primOp,
  input logic [9:0]        extOp,
  input logic              oeBit,
  input logic              rcBit,
  input logic              raIsZero,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [IMM_W-1:0]  imm,
  input logic              carryIn,
  input logic              sumOvIn,
  input logic [DATA_W-1:0] result,
  input logic              resultWe,
  input logic              carryOut,
  input logic              carryWe,
  input logic              ovOut,
  input logic              ovWe,
  input logic              soOut,
  input logic [3:0]        cr0,
  input logic              cr0We
);

  logic known;
  assign known = !$isunknown({primOp, extOp, oeBit, rcBit, sumOvIn, result});

  always_comb begin
    if (known) begin
      // R5: carry is only written by opcode 31 or the carrying immediate forms
      if (carryWe)
        assert_carry_source_R5: assert (primOp == 6'd31 || primOp == 6'd12 ||
                                        primOp == 6'd13 || primOp == 6'd8);
      // R6: overflow write needs a register-register form with OE
      if (ovWe)
        assert_ov_needs_oe_R6: assert (primOp == 6'd31 && oeBit);
      // R6: summary overflow never clears
      if (sumOvIn)
        assert_so_sticky_R6: assert (soOut);
      // R7: EQ flag tracks a zero result, exactly one of LT/GT/EQ
      if (cr0We)
        assert_cr0_eq_R7: assert (cr0[1] == (result == '0) && $onehot(cr0[3:1]));
      // R7: the recording carry-immediate form always writes CR0
      if (primOp == 6'd13)
        assert_addicr_cr0_R7: assert (cr0We && carryWe);
      // R8: nothing is written without a result
      if (!resultWe)
        assert_idle_quiet_R8: assert (!carryWe && !ovWe && !cr0We && soOut == sumOvIn);
    end
  end

endmodule

bind addSubUnit addSubUnit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/addSubUnit_bench.sv
module addSubUnit_bench;

  typedef struct packed {
    logic [15:0] tag;
    logic [5:0]  p;
    logic [9:0]  x;
    logic        oe;
    logic        rc;
    logic        rz;
    logic        ca;
    logic        so;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] i;
    logic        eResWe;
    logic [31:0] eRes;
    logic        eCaWe;
    logic        eCa;
    logic        eOvWe;
    logic        eOv;
    logic        eSo;
    logic        eCrWe;
    logic [3:0]  eCr;
  } vecT;

  localparam int NV = 22;
  localparam vecT VECS [NV] = '{
    '{"R1", 6'd31, 10'd266, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'd5, 32'd7, 16'h0,
      1'b1, 32'd12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0100},
    '{"R6", 6'd31, 10'd266, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h7FFFFFFF, 32'd1, 16'h0,
      1'b1, 32'h80000000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1001},
    '{"R6", 6'd31, 10'd266, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'd1, 32'd1, 16'h0,
      1'b1, 32'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0101},
    '{"R5", 6'd31, 10'd10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'd1, 16'h0,
      1'b1, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0010},
    '{"R2", 6'd31, 10'd40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd3, 32'd10, 16'h0,
      1'b1, 32'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000},
    '{"R6", 6'd31, 10'd40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'd1, 32'h80000000, 16'h0,
      1'b1, 32'h7FFFFFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0000},
    '{"R5", 6'd31, 10'd8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'd10, 32'd3, 16'h0,
      1'b1, 32'hFFFFFFF9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1000},
    '{"R5", 6'd31, 10'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd3, 32'd10, 16'h0,
      1'b1, 32'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{"R2", 6'd31, 10'd136, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd3, 32'd10, 16'h0,
      1'b1, 32'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{"R2", 6'd31, 10'd136, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'd10, 32'd3, 16'h0,
      1'b1, 32'hFFFFFFF9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{"R3", 6'd31, 10'd104, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h80000000, 32'h12345678, 16'h0,
      1'b1, 32'h80000000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1001},
    '{"R3", 6'd31, 10'd104, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd5, 32'hFFFFFFFF, 16'h0,
      1'b1, 32'hFFFFFFFB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{"R4", 6'd14, 10'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h1234, 32'd0, 16'hFFFF,
      1'b1, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{"R4", 6'd14, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h100, 32'd0, 16'h0010,
      1'b1, 32'h110, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{"R4", 6'd15, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd1, 32'd0, 16'h0002,
      1'b1, 32'h20001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{"R4", 6'd15, 10'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h55, 32'd0, 16'h8000,
      1'b1, 32'h80000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{"R9", 6'd12, 10'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'd0, 16'h0001,
      1'b1, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{"R7", 6'd13, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 32'd0, 16'hFFFF,
      1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1001},
    '{"R9", 6'd8, 10'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'd1, 32'd0, 16'h0005,
      1'b1, 32'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{"R9", 6'd8, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd6, 32'd0, 16'h0005,
      1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    '{"R8", 6'd31, 10'd444, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h7FFFFFFF, 32'd1, 16'h0,
      1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000},
    '{"R8", 6'd7, 10'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'd9, 32'd9, 16'h0009,
      1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  primOp = '0;
  logic [9:0]  extOp = '0;
  logic        oeBit = 1'b0;
  logic        rcBit = 1'b0;
  logic        raIsZero = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] imm = '0;
  logic        carryIn = 1'b0;
  logic        sumOvIn = 1'b0;
  logic [31:0] result;
  logic        resultWe, carryOut, carryWe, ovOut, ovWe, soOut, cr0We;
  logic [3:0]  cr0;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  addSubUnit u_addSubUnit (
    .primOp(primOp), .extOp(extOp), .oeBit(oeBit), .rcBit(rcBit),
    .raIsZero(raIsZero), .opA(opA), .opB(opB), .imm(imm),
    .carryIn(carryIn), .sumOvIn(sumOvIn), .result(result),
    .resultWe(resultWe), .carryOut(carryOut), .carryWe(carryWe),
    .ovOut(ovOut), .ovWe(ovWe), .soOut(soOut), .cr0(cr0), .cr0We(cr0We)
  );

  task automatic check(input string req, input string what, input int idx,
                       input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s vec %0d %s: actual %h expected %h", req, idx, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset/idle state: opcode 0 writes nothing (R8)
    @(negedge clk);
    #1;
    check("R8", "idle resultWe", -1, {31'd0, resultWe}, 32'd0);
    check("R8", "idle carryWe", -1, {31'd0, carryWe}, 32'd0);
    check("R8", "idle ovWe", -1, {31'd0, ovWe}, 32'd0);
    check("R8", "idle cr0We", -1, {31'd0, cr0We}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      vecT v;
      string t;
      v = VECS[k];
      t = string'(v.tag);
      @(negedge clk);
      primOp = v.p; extOp = v.x; oeBit = v.oe; rcBit = v.rc; raIsZero = v.rz;
      carryIn = v.ca; sumOvIn = v.so; opA = v.a; opB = v.b; imm = v.i;
      #1;
      check(t, "resultWe", k, {31'd0, resultWe}, {31'd0, v.eResWe});
      if (v.eResWe) check(t, "result", k, result, v.eRes);
      check(t, "carryWe", k, {31'd0, carryWe}, {31'd0, v.eCaWe});
      if (v.eCaWe) check(t, "carryOut", k, {31'd0, carryOut}, {31'd0, v.eCa});
      check(t, "ovWe", k, {31'd0, ovWe}, {31'd0, v.eOvWe});
      if (v.eOvWe) check(t, "ovOut", k, {31'd0, ovOut}, {31'd0, v.eOv});
      check(t, "soOut", k, {31'd0, soOut}, {31'd0, v.eSo});
      check(t, "cr0We", k, {31'd0, cr0We}, {31'd0, v.eCrWe});
      if (v.eCrWe) check(t, "cr0", k, {28'd0, cr0}, {28'd0, v.eCr});
    end

    // R3: negate ignores opB entirely
    @(negedge clk);
    primOp = 6'd31; extOp = 10'd104; oeBit = 1'b0; rcBit = 1'b0; raIsZero = 1'b0;
    opA = 32'd1; opB = 32'hDEADBEEF; carryIn = 1'b1; sumOvIn = 1'b0;
    #1;
    check("R3", "neg with noise on opB", 100, result, 32'hFFFFFFFF);
    // R1: add wraps modulo 2^32, no carry written
    @(negedge clk);
    extOp = 10'd266; opA = 32'hFFFFFFFF; opB = 32'd2;
    #1;
    check("R1", "add wrap", 101, result, 32'd1);
    check("R1", "add carryWe", 101, {31'd0, carryWe}, 32'd0);
    // R4: addi with zero-base flag ignores opA
    @(negedge clk);
    primOp = 6'd14; raIsZero = 1'b1; opA = 32'hFFFF0000; imm = 16'h7FFF;
    #1;
    check("R4", "addi zero base", 102, result, 32'h00007FFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule